// File: doc/BRIEF.md
# Lockable Hardware Over-Temperature Comparator

This block keeps the hardware over-temperature thresholds for one on-die sensor and a configurable number of remote diode channels (two by default). Each time the converter presents a new set of readings, the block compares every reading against its thresholds. It then registers one error flag per channel. These flags drive the interrupt request line directly and are never recorded in any status register.

The on-die reading has two thresholds of its own: a primary one and a secondary one. All remote channels share a single primary/secondary pair. Each remote reading is checked against both shared thresholds separately. Software programs the thresholds through a simple address/data/strobe write port and reads them back through a combinational read port.

A configuration register holds two one-way lock bits. One freezes the on-die primary threshold and the other freezes the shared remote primary threshold. Once set, a lock bit stays set until the block is reset. Writes to a locked threshold complete with no effect.

Top module: `hwt_limit_mon`

## Requirements
- R1: After reset every threshold reads back 7Fh, the configuration register reads 00h, all error flags are 0 and `hw_irq` is 0.
- R2: A write strobe to an unlocked threshold address (13h on-die primary, 17h on-die secondary, 14h remote primary, 18h remote secondary) stores the data. The data reads back at that address from the next cycle. Unmapped addresses read back 00h, and writes to them change nothing.
- R3: Writing configuration address 4Ah with bit 1 set locks the on-die primary threshold (13h). Later writes to 13h leave its value unchanged, and reads still return the held value.
- R4: Writing 4Ah with bit 2 set locks the shared remote primary threshold (14h). The secondary thresholds at 17h and 18h stay writable under either lock.
- R5: The lock bits are one-way. A write of 0 to a set lock bit is ignored, and only reset clears them. Address 4Ah reads back the on-die lock in bit 1 and the remote lock in bit 2, with all other bits 0.
- R6: On a cycle with `conv_valid` high, `hw_err` bit 0 takes 1 exactly when the on-die reading is strictly greater than the 13h threshold or strictly greater than the 17h threshold. A reading equal to a threshold does not flag.
- R7: On a cycle with `conv_valid` high, `hw_err` bit k+1 takes 1 exactly when remote channel k (`ext_temp` bits 8k+7..8k) is strictly greater than the 14h threshold or strictly greater than the 18h threshold. Every channel is compared on its own.
- R8: The flags change only on cycles with `conv_valid` high and are held otherwise. `hw_irq` is high whenever any flag is set.
- R9: Readings and thresholds are compared as signed 8-bit two's complement, so FFh (-1) is not above 00h and 80h is the lowest value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| conv_valid | input | 1 | New conversion readings present this cycle |
| int_temp | input | 8 | On-die reading, signed |
| ext_temp | input | 16 | Remote readings, channel k in bits 8k+7..8k, signed |
| hw_err | output | 3 | Registered error flags: bit 0 on-die, bit k+1 remote channel k |
| hw_irq | output | 1 | OR of the error flags |

## Verification
The bench drives readings equal to a threshold and one count above it. A design that used greater-or-equal would flag the equal case. Negative readings against a zero threshold catch an unsigned compare, which would see FFh as large. The bench sets one remote channel above only the primary threshold and the other above only the secondary one. A design that compared each channel against just one threshold, or mixed up channels, would produce the wrong bit pattern. It also writes locked addresses and writes 0 to set lock bits. Any lock that leaks or clears shows up as a changed read-back or a wrong 4Ah value, and reset is then shown to clear the locks.

// File: rtl/hwt_pkg.sv
package hwt_pkg;
    parameter int TEMP_W = 8;
    parameter int ADDR_W = 8;

    typedef logic [TEMP_W-1:0] temp_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // threshold register state
    typedef struct packed {
        temp_t int_a;
        temp_t int_b;
        temp_t ext_a;
        temp_t ext_b;
        logic  lock_int;
        logic  lock_ext;
    } lim_state_t;

    function automatic logic above(input temp_t rd, input temp_t lim);
        return $signed(rd) > $signed(lim);
    endfunction
endpackage

// File: rtl/hwt_limit_regs.sv
module hwt_limit_regs
    import hwt_pkg::*;
#(
    parameter addr_t ADDR_INT_A   = 8'h13,
    parameter addr_t ADDR_EXT_A   = 8'h14,
    parameter addr_t ADDR_INT_B   = 8'h17,
    parameter addr_t ADDR_EXT_B   = 8'h18,
    parameter addr_t ADDR_CFG     = 8'h4A,
    parameter int    LOCK_INT_BIT = 1,
    parameter int    LOCK_EXT_BIT = 2,
    parameter int    LIMIT_RST    = 127
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  addr_t wr_addr,
    input  temp_t wr_data,
    input  addr_t rd_addr,
    output temp_t rd_data,
    output temp_t lim_int_a,
    output temp_t lim_int_b,
    output temp_t lim_ext_a,
    output temp_t lim_ext_b,
    output logic  lock_int,
    output logic  lock_ext
);
    localparam temp_t RST_VAL = temp_t'(LIMIT_RST);

    lim_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_addr == ADDR_INT_A && !st_q.lock_int) st_d.int_a = wr_data;
            if (wr_addr == ADDR_EXT_A && !st_q.lock_ext) st_d.ext_a = wr_data;
            if (wr_addr == ADDR_INT_B) st_d.int_b = wr_data;
            if (wr_addr == ADDR_EXT_B) st_d.ext_b = wr_data;
            if (wr_addr == ADDR_CFG) begin
                // one-way: only a 1 can change the bit
                st_d.lock_int = st_q.lock_int | wr_data[LOCK_INT_BIT];
                st_d.lock_ext = st_q.lock_ext | wr_data[LOCK_EXT_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{int_a: RST_VAL, int_b: RST_VAL, ext_a: RST_VAL,
                      ext_b: RST_VAL, lock_int: 1'b0, lock_ext: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_INT_A) rd_data = st_q.int_a;
        if (rd_addr == ADDR_EXT_A) rd_data = st_q.ext_a;
        if (rd_addr == ADDR_INT_B) rd_data = st_q.int_b;
        if (rd_addr == ADDR_EXT_B) rd_data = st_q.ext_b;
        if (rd_addr == ADDR_CFG) begin
            rd_data[LOCK_INT_BIT] = st_q.lock_int;
            rd_data[LOCK_EXT_BIT] = st_q.lock_ext;
        end
    end

    assign lim_int_a = st_q.int_a;
    assign lim_int_b = st_q.int_b;
    assign lim_ext_a = st_q.ext_a;
    assign lim_ext_b = st_q.ext_b;
    assign lock_int  = st_q.lock_int;
    assign lock_ext  = st_q.lock_ext;
endmodule

// File: rtl/hwt_cmp.sv
module hwt_cmp
    import hwt_pkg::*;
#(
    parameter int NUM_EXT = 2
) (
    input  temp_t                   int_temp,
    input  logic [NUM_EXT*TEMP_W-1:0] ext_temp,
    input  temp_t                   lim_int_a,
    input  temp_t                   lim_int_b,
    input  temp_t                   lim_ext_a,
    input  temp_t                   lim_ext_b,
    output logic [NUM_EXT:0]        hit
);
    assign hit[0] = above(int_temp, lim_int_a) | above(int_temp, lim_int_b);

    for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
        temp_t rd;
        assign rd       = ext_temp[k*TEMP_W +: TEMP_W];
        assign hit[k+1] = above(rd, lim_ext_a) | above(rd, lim_ext_b);
    end
endmodule

// File: rtl/hwt_limit_mon.sv
module hwt_limit_mon
    import hwt_pkg::*;
#(
    parameter int    NUM_EXT      = 2,
    parameter addr_t ADDR_INT_A   = 8'h13,
    parameter addr_t ADDR_EXT_A   = 8'h14,
    parameter addr_t ADDR_INT_B   = 8'h17,
    parameter addr_t ADDR_EXT_B   = 8'h18,
    parameter addr_t ADDR_CFG     = 8'h4A,
    parameter int    LOCK_INT_BIT = 1,
    parameter int    LOCK_EXT_BIT = 2,
    parameter int    LIMIT_RST    = 127
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [TEMP_W-1:0]         wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [TEMP_W-1:0]         rd_data,
    input  logic                      conv_valid,
    input  logic [TEMP_W-1:0]         int_temp,
    input  logic [NUM_EXT*TEMP_W-1:0] ext_temp,
    output logic [NUM_EXT:0]          hw_err,
    output logic                      hw_irq
);
    temp_t lim_int_a, lim_int_b, lim_ext_a, lim_ext_b;
    logic  lock_int, lock_ext;
    logic [NUM_EXT:0] hit;
    logic [NUM_EXT:0] err_d, err_q;

    hwt_limit_regs #(
        .ADDR_INT_A(ADDR_INT_A), .ADDR_EXT_A(ADDR_EXT_A),
        .ADDR_INT_B(ADDR_INT_B), .ADDR_EXT_B(ADDR_EXT_B),
        .ADDR_CFG(ADDR_CFG), .LOCK_INT_BIT(LOCK_INT_BIT),
        .LOCK_EXT_BIT(LOCK_EXT_BIT), .LIMIT_RST(LIMIT_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .lim_int_a(lim_int_a), .lim_int_b(lim_int_b),
        .lim_ext_a(lim_ext_a), .lim_ext_b(lim_ext_b),
        .lock_int(lock_int), .lock_ext(lock_ext)
    );

    hwt_cmp #(.NUM_EXT(NUM_EXT)) u_cmp (
        .int_temp(int_temp), .ext_temp(ext_temp),
        .lim_int_a(lim_int_a), .lim_int_b(lim_int_b),
        .lim_ext_a(lim_ext_a), .lim_ext_b(lim_ext_b),
        .hit(hit)
    );

    always_comb begin
        err_d = err_q;
        if (conv_valid) err_d = hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end

    assign hw_err = err_q;
    assign hw_irq = |err_q;
endmodule

// File: rtl/hwt_limit_chk.sv
module hwt_limit_chk
    import hwt_pkg::*;
#(
    parameter int    NUM_EXT    = 2,
    parameter addr_t ADDR_INT_A = 8'h13,
    parameter addr_t ADDR_EXT_A = 8'h14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input addr_t             wr_addr,
    input logic              conv_valid,
    input temp_t             int_temp,
    input logic [NUM_EXT:0]  hw_err,
    input logic              hw_irq,
    input logic              lock_int,
    input logic              lock_ext,
    input temp_t             lim_int_a,
    input temp_t             lim_int_b,
    input temp_t             lim_ext_a
);
    // R5
    lock_int_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_int |=> lock_int);
    // R5
    lock_ext_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_ext |=> lock_ext);
    // R3
    int_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_int && wr_en && wr_addr == ADDR_INT_A) |=> $stable(lim_int_a));
    // R4
    ext_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_ext && wr_en && wr_addr == ADDR_EXT_A) |=> $stable(lim_ext_a));
    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_valid |=> $stable(hw_err));
    // R8
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_err != '0) |-> hw_irq);
    // R6
    int_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_valid && ($signed(int_temp) > $signed(lim_int_a)
                     || $signed(int_temp) > $signed(lim_int_b))) |=> hw_err[0]);
    // R6
    int_under_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_valid && $signed(int_temp) <= $signed(lim_int_a)
                    && $signed(int_temp) <= $signed(lim_int_b)) |=> !hw_err[0]);
endmodule

bind hwt_limit_mon hwt_limit_chk #(
    .NUM_EXT(NUM_EXT), .ADDR_INT_A(ADDR_INT_A), .ADDR_EXT_A(ADDR_EXT_A)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .conv_valid(conv_valid), .int_temp(int_temp), .hw_err(hw_err),
    .hw_irq(hw_irq), .lock_int(lock_int), .lock_ext(lock_ext),
    .lim_int_a(lim_int_a), .lim_int_b(lim_int_b), .lim_ext_a(lim_ext_a)
);

// File: tb/hwt_limit_mon_bench.sv
`timescale 1ns/1ps
module hwt_limit_mon_bench;
    localparam logic [7:0] A_IA = 8'h13, A_EA = 8'h14, A_IB = 8'h17,
                           A_EB = 8'h18, A_CF = 8'h4A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
    logic [7:0] rd_data;
    logic conv_valid = 1'b0;
    logic [7:0] int_temp = '0;
    logic [15:0] ext_temp = '0;
    logic [2:0] hw_err;
    logic hw_irq;

    int tests = 0, fails = 0;
    bit done = 0;

    logic [7:0] m_ia, m_ib, m_ea, m_eb;
    logic m_li, m_le;

    always #4 clk = ~clk;

    hwt_limit_mon u_hwt_limit_mon (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .conv_valid(conv_valid), .int_temp(int_temp), .ext_temp(ext_temp),
        .hw_err(hw_err), .hw_irq(hw_irq)
    );

    function automatic logic gt(input logic [7:0] a, input logic [7:0] b);
        return $signed(a) > $signed(b);
    endfunction

    function automatic logic [2:0] exp_err(input logic [7:0] t,
                                           input logic [7:0] e0,
                                           input logic [7:0] e1);
        return {gt(e1, m_ea) | gt(e1, m_eb),
                gt(e0, m_ea) | gt(e0, m_eb),
                gt(t, m_ia) | gt(t, m_ib)};
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        case (a)
            A_IA: return m_ia;
            A_EA: return m_ea;
            A_IB: return m_ib;
            A_EB: return m_eb;
            A_CF: return {5'b0, m_le, m_li, 1'b0};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ia = 8'h7F; m_ib = 8'h7F; m_ea = 8'h7F; m_eb = 8'h7F;
        m_li = 0; m_le = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        model_reset();
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        case (a)
            A_IA: if (!m_li) m_ia = d;
            A_EA: if (!m_le) m_ea = d;
            A_IB: m_ib = d;
            A_EB: m_eb = d;
            A_CF: begin m_li = m_li | d[1]; m_le = m_le | d[2]; end
            default: ;
        endcase
    endtask

    task automatic do_rd(input logic [7:0] a, input string req);
        rd_addr = a;
        #1;
        chk(rd_data === exp_rd(a), req, rd_data, exp_rd(a));
    endtask

    task automatic do_conv(input logic [7:0] t, input logic [7:0] e0,
                           input logic [7:0] e1, input string req);
        logic [2:0] e;
        @(negedge clk);
        conv_valid = 1; int_temp = t; ext_temp = {e1, e0};
        e = exp_err(t, e0, e1);
        @(negedge clk);
        conv_valid = 0;
        chk(hw_err === e, req, hw_err, e);
        chk(hw_irq === (|e), "R8 irq", hw_irq, |e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [2:0] held;
        void'($urandom(32'd7741));
        model_reset();
        do_reset();
        // R1 reset state
        do_rd(A_IA, "R1 ia"); do_rd(A_IB, "R1 ib");
        do_rd(A_EA, "R1 ea"); do_rd(A_EB, "R1 eb"); do_rd(A_CF, "R1 cfg");
        chk(hw_err === 3'b000, "R1 err", hw_err, 0);
        chk(hw_irq === 1'b0, "R1 irq", hw_irq, 0);
        // R2 write/readback and unmapped
        do_wr(A_IA, 8'd50); do_rd(A_IA, "R2 ia");
        do_wr(A_IB, 8'd60); do_rd(A_IB, "R2 ib");
        do_wr(8'h20, 8'hAA); do_rd(8'h20, "R2 unmapped");
        // R6 equal does not flag, one above does
        do_conv(8'd50, 8'd0, 8'd0, "R6 equal");
        do_conv(8'd51, 8'd0, 8'd0, "R6 above primary");
        do_wr(A_IA, 8'h7F);
        do_conv(8'd60, 8'd0, 8'd0, "R6 equal secondary");
        do_conv(8'd61, 8'd0, 8'd0, "R6 above secondary");
        // R7 shared remote thresholds, each channel alone
        do_wr(A_EA, 8'd20); do_wr(A_EB, 8'h7F);
        do_conv(8'd0, 8'd21, 8'd20, "R7 ch0 over primary");
        do_wr(A_EA, 8'h7F); do_wr(A_EB, 8'd10);
        do_conv(8'd0, 8'd10, 8'd11, "R7 ch1 over secondary");
        // R9 signed compare
        do_wr(A_IB, 8'h00);
        do_conv(8'hFF, 8'h80, 8'hFF, "R9 negative");
        do_conv(8'h01, 8'h7F, 8'h80, "R9 positive");
        // R8 hold without conv_valid
        held = hw_err;
        @(negedge clk);
        int_temp = 8'h80; ext_temp = 16'h8080;
        repeat (3) @(negedge clk);
        chk(hw_err === held, "R8 hold", hw_err, held);
        // R3 lock on-die primary
        do_wr(A_IA, 8'd40);
        do_wr(A_CF, 8'h02);
        do_wr(A_IA, 8'd33); do_rd(A_IA, "R3 locked hold");
        do_wr(A_IB, 8'd22); do_rd(A_IB, "R3 secondary writable");
        // R4 lock remote primary, R5 zero write ignored
        do_wr(A_CF, 8'h04);
        do_rd(A_CF, "R5 both locks");
        do_wr(A_EA, 8'd5); do_rd(A_EA, "R4 locked hold");
        do_wr(A_EB, 8'd6); do_rd(A_EB, "R4 secondary writable");
        do_wr(A_CF, 8'h00); do_rd(A_CF, "R5 zero ignored");
        do_conv(8'd41, 8'd7, 8'd6, "R7 after locks");
        // R5 reset clears locks
        do_reset();
        do_rd(A_CF, "R5 reset clears");
        do_wr(A_IA, 8'd12); do_rd(A_IA, "R5 writable after reset");
        // random phase
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 5) begin
                logic [7:0] a;
                case ($urandom_range(0, 11))
                    0, 1, 2: a = A_IA;
                    3, 4:    a = A_IB;
                    5, 6:    a = A_EA;
                    7, 8:    a = A_EB;
                    9:       a = A_CF;
                    default: a = 8'($urandom_range(0, 255));
                endcase
                do_wr(a, 8'($urandom_range(0, 255)));
                do_rd(a, "R2 random readback");
            end else begin
                do_conv(8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)),
                        8'($urandom_range(0, 255)), "R7 random conv");
            end
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule